// File: doc/BRIEF.md
# I2C Command-Pointer Register Target

This block is an I2C target that gives a bus master access to four 8-bit registers of a small port expander: a view of the input pins, an output latch, a polarity-inversion mask and a direction (configuration) mask. The first byte after the device address is a command byte. It loads a register pointer, and every later byte of the transfer uses that pointer.

The master reads a register in one of two ways. It can write the command byte, issue a repeated start and then address the device for reading. Or it can address the device for reading straight away, and the block returns the register the pointer still names from an earlier transfer. The pointer does not advance inside a burst, so every byte of a multi-byte read or write uses the same register.

The block samples SCL and SDA on its own clock through a two-flop synchronizer. It pulls SDA low through an open-drain enable. The register values and a bus-busy flag are plain outputs. The block has no streaming interface, so there are no valid/ready rules to follow.

Top module: `i2cx_target`

## Requirements
- R1: The device address is the fixed prefix 4'b0100 followed by `addr_pins[2:0]`, with the read/write bit after it (1 = read). A matching address is acknowledged. A non-matching address is not acknowledged, and no later byte is acknowledged or applied until the next start condition.
- R2: Command byte values 0, 1, 2 and 3 select the input, output, polarity and configuration registers and are acknowledged. Any other value is not acknowledged and leaves the pointer unchanged, and the rest of the transfer is ignored.
- R3: Every write data byte after the command byte is acknowledged and written to the selected register, so the last byte of a burst is the value that remains.
- R4: The input register cannot be written. A write to it is acknowledged and changes no register. Reading it returns the captured pin values XORed with the polarity register.
- R5: After a repeated start, a read returns the register selected by the command byte of the write phase. A read with no command phase returns the register named by the most recent valid command, even from an earlier transaction.
- R6: A read burst has no length limit. While the master acknowledges, each byte returns the selected register again. After a byte the master does not acknowledge, the block leaves SDA released.
- R7: The pins are captured on the rising SCL edge of each acknowledge slot in a read, and of the address acknowledge. The next byte returns the captured value, and later pin changes do not affect it.
- R8: A stop condition at any point, including in the middle of a byte, releases SDA, clears `bus_busy` and leaves the registers unchanged.
- R9: `sda_oe` changes only while SCL is low.
- R10: After reset, SDA is released, `bus_busy` is 0, the output register is 8'hFF, the polarity register is 8'h00, the configuration register is 8'hFF, and the pointer selects the input register.
- R11: A start condition (SDA falling while SCL is high) sets `bus_busy`, and a stop condition (SDA rising while SCL is high) clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SCL level from the pad |
| sda_i | input | 1 | SDA level from the pad (wired bus value) |
| sda_oe | output | 1 | 1 pulls SDA low; 0 releases it |
| addr_pins | input | 3 | Low address bits set by board straps |
| port_in | input | 8 | Input pin levels |
| out_q | output | 8 | Output register value |
| pol_q | output | 8 | Polarity-inversion register value |
| cfg_q | output | 8 | Configuration register value |
| bus_busy | output | 1 | High between a start and a stop condition |

## Verification
The hardest case to reach from the ports is the input capture at the acknowledge clock. The pins must change after the rising SCL edge of a master acknowledge but before the next data byte goes out. Only then does the test show that the byte carries the captured value and not the live pins. The bench's read task can change the pins in the high phase of its own acknowledge bit, and the scoreboard expects the old value for the next byte and the new value for the byte after it. A stop in the middle of a byte is forced by driving half a data byte by hand and then closing the bus.

// File: rtl/i2cx_pkg.sv
package i2cx_pkg;

  // Link-layer protocol phases
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_CMD,
    ST_CMD_ACK,
    ST_WDAT,
    ST_WDAT_ACK,
    ST_RDAT,
    ST_RACK,
    ST_SKIP
  } link_state_e;

  localparam int unsigned NUM_REGS  = 4;
  localparam int unsigned SEL_W     = $clog2(NUM_REGS);

  // Register pointer encodings (the command byte value)
  localparam logic [SEL_W-1:0] SEL_IN  = 2'd0;
  localparam logic [SEL_W-1:0] SEL_OUT = 2'd1;
  localparam logic [SEL_W-1:0] SEL_POL = 2'd2;
  localparam logic [SEL_W-1:0] SEL_CFG = 2'd3;

endpackage

// File: rtl/i2cx_line_sync.sv
module i2cx_line_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_q,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);

  localparam int unsigned LAST = STAGES - 1;

  logic [LAST:0] scl_pipe;
  logic [LAST:0] sda_pipe;
  logic          scl_prev;
  logic          sda_prev;
  logic          scl_q;

  // Idle bus is high on both lines, so the pipes reset to ones
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_prev <= 1'b1;
      sda_prev <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[LAST-1:0], scl_i};
      sda_pipe <= {sda_pipe[LAST-1:0], sda_i};
      scl_prev <= scl_pipe[LAST];
      sda_prev <= sda_pipe[LAST];
    end
  end

  assign scl_q    = scl_pipe[LAST];
  assign sda_q    = sda_pipe[LAST];
  assign scl_rise = scl_q & ~scl_prev;
  assign scl_fall = ~scl_q & scl_prev;
  // An SDA edge is a bus condition only when SCL is steady high
  assign start_ev = scl_q & scl_prev & sda_prev & ~sda_q;
  assign stop_ev  = scl_q & scl_prev & ~sda_prev & sda_q;

endmodule

// File: rtl/i2cx_link.sv
module i2cx_link
  import i2cx_pkg::*;
#(
  parameter int unsigned DW       = 8,
  parameter int unsigned PREFIX_W = 4,
  parameter int unsigned PIN_W    = 3,
  parameter logic [PREFIX_W-1:0] ADDR_PREFIX = 4'b0100
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sda_q,
  input  logic             scl_rise,
  input  logic             scl_fall,
  input  logic             start_ev,
  input  logic             stop_ev,
  input  logic [PIN_W-1:0] addr_pins,
  input  logic [DW-1:0]    rd_data,
  output logic             sda_oe,
  output logic             busy,
  output logic [SEL_W-1:0] sel,
  output logic             wr_en,
  output logic [DW-1:0]    wr_data,
  output logic             cap_en
);

  localparam int unsigned DEV_W = PREFIX_W + PIN_W;
  localparam int unsigned CNT_W = $clog2(DW + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(DW);

  link_state_e      state;
  logic [CNT_W-1:0] cnt;
  logic [DW-1:0]    rx_sh;
  logic [DW-1:0]    tx_sh;
  logic             rnw;
  logic             rack_ok;
  logic [DEV_W-1:0] my_addr;

  assign my_addr = {ADDR_PREFIX, addr_pins};

  // Pin capture at the rising edge of an acknowledge clock
  assign cap_en = scl_rise & ((state == ST_ADDR_ACK) | (state == ST_RACK));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      rx_sh   <= '0;
      tx_sh   <= '0;
      rnw     <= 1'b0;
      rack_ok <= 1'b0;
      sda_oe  <= 1'b0;
      busy    <= 1'b0;
      sel     <= SEL_IN;
      wr_en   <= 1'b0;
      wr_data <= '0;
    end else begin
      wr_en <= 1'b0;
      if (start_ev) begin
        state  <= ST_ADDR;
        cnt    <= '0;
        sda_oe <= 1'b0;
        busy   <= 1'b1;
      end else if (stop_ev) begin
        state  <= ST_IDLE;
        cnt    <= '0;
        sda_oe <= 1'b0;
        busy   <= 1'b0;
      end else begin
        unique case (state)
          ST_ADDR, ST_CMD, ST_WDAT: begin
            if (scl_rise) begin
              rx_sh <= {rx_sh[DW-2:0], sda_q};
              cnt   <= cnt + 1'b1;
            end else if (scl_fall && cnt == FULL) begin
              if (state == ST_ADDR) begin
                if (rx_sh[DW-1 -: DEV_W] == my_addr) begin
                  rnw    <= rx_sh[0];
                  sda_oe <= 1'b1;
                  state  <= ST_ADDR_ACK;
                end else begin
                  state <= ST_SKIP;
                end
              end else if (state == ST_CMD) begin
                if (rx_sh < DW'(NUM_REGS)) begin
                  sel    <= rx_sh[SEL_W-1:0];
                  sda_oe <= 1'b1;
                  state  <= ST_CMD_ACK;
                end else begin
                  state <= ST_SKIP;
                end
              end else begin
                wr_en   <= 1'b1;
                wr_data <= rx_sh;
                sda_oe  <= 1'b1;
                state   <= ST_WDAT_ACK;
              end
            end
          end
          ST_ADDR_ACK: begin
            if (scl_fall) begin
              if (rnw) begin
                tx_sh  <= rd_data;
                sda_oe <= ~rd_data[DW-1];
                cnt    <= CNT_W'(1);
                state  <= ST_RDAT;
              end else begin
                sda_oe <= 1'b0;
                cnt    <= '0;
                state  <= ST_CMD;
              end
            end
          end
          ST_CMD_ACK, ST_WDAT_ACK: begin
            if (scl_fall) begin
              sda_oe <= 1'b0;
              cnt    <= '0;
              state  <= ST_WDAT;
            end
          end
          ST_RDAT: begin
            if (scl_fall) begin
              if (cnt == FULL) begin
                sda_oe <= 1'b0;
                state  <= ST_RACK;
              end else begin
                tx_sh  <= {tx_sh[DW-2:0], 1'b0};
                sda_oe <= ~tx_sh[DW-2];
                cnt    <= cnt + 1'b1;
              end
            end
          end
          ST_RACK: begin
            if (scl_rise) begin
              rack_ok <= ~sda_q;
            end else if (scl_fall) begin
              if (rack_ok) begin
                tx_sh  <= rd_data;
                sda_oe <= ~rd_data[DW-1];
                cnt    <= CNT_W'(1);
                state  <= ST_RDAT;
              end else begin
                sda_oe <= 1'b0;
                state  <= ST_SKIP;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/i2cx_regs.sv
module i2cx_regs
  import i2cx_pkg::*;
#(
  parameter int unsigned DW = 8,
  parameter logic [NUM_REGS*DW-1:0] RST_VALS = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [SEL_W-1:0] sel,
  input  logic [DW-1:0]    wr_data,
  input  logic             cap_en,
  input  logic [DW-1:0]    port_in,
  output logic [DW-1:0]    rd_data,
  output logic [DW-1:0]    out_q,
  output logic [DW-1:0]    pol_q,
  output logic [DW-1:0]    cfg_q
);

  logic [DW-1:0] bank_q [1:NUM_REGS-1];
  logic [DW-1:0] pin_cap;

  // Writable registers; slot 0 (input view) has no storage to write
  for (genvar g = 1; g < NUM_REGS; g++) begin : g_bank
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        bank_q[g] <= RST_VALS[g*DW +: DW];
      end else if (wr_en && sel == SEL_W'(g)) begin
        bank_q[g] <= wr_data;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_cap <= '0;
    end else if (cap_en) begin
      pin_cap <= port_in;
    end
  end

  assign out_q = bank_q[SEL_OUT];
  assign pol_q = bank_q[SEL_POL];
  assign cfg_q = bank_q[SEL_CFG];

  always_comb begin
    unique case (sel)
      SEL_IN:  rd_data = pin_cap ^ pol_q;
      SEL_OUT: rd_data = out_q;
      SEL_POL: rd_data = pol_q;
      default: rd_data = cfg_q;
    endcase
  end

endmodule

// File: rtl/i2cx_target.sv
module i2cx_target
  import i2cx_pkg::*;
#(
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned PIN_W       = 3,
  parameter int unsigned PREFIX_W    = 4,
  parameter logic [PREFIX_W-1:0] ADDR_PREFIX = 4'b0100,
  parameter int unsigned SYNC_STAGES = 2,
  parameter logic [DATA_W-1:0] OUT_RST = 8'hFF,
  parameter logic [DATA_W-1:0] POL_RST = 8'h00,
  parameter logic [DATA_W-1:0] CFG_RST = 8'hFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  input  logic [PIN_W-1:0]  addr_pins,
  input  logic [DATA_W-1:0] port_in,
  output logic [DATA_W-1:0] out_q,
  output logic [DATA_W-1:0] pol_q,
  output logic [DATA_W-1:0] cfg_q,
  output logic              bus_busy
);

  localparam logic [NUM_REGS*DATA_W-1:0] RST_VALS =
    {CFG_RST, POL_RST, OUT_RST, {DATA_W{1'b0}}};

  logic              sda_q;
  logic              scl_rise;
  logic              scl_fall;
  logic              start_ev;
  logic              stop_ev;
  logic [SEL_W-1:0]  sel;
  logic              wr_en;
  logic [DATA_W-1:0] wr_data;
  logic              cap_en;
  logic [DATA_W-1:0] rd_data;

  i2cx_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_i    (scl_i),
    .sda_i    (sda_i),
    .sda_q    (sda_q),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_ev (start_ev),
    .stop_ev  (stop_ev)
  );

  i2cx_link #(
    .DW          (DATA_W),
    .PREFIX_W    (PREFIX_W),
    .PIN_W       (PIN_W),
    .ADDR_PREFIX (ADDR_PREFIX)
  ) u_link (
    .clk       (clk),
    .rst_n     (rst_n),
    .sda_q     (sda_q),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_ev  (start_ev),
    .stop_ev   (stop_ev),
    .addr_pins (addr_pins),
    .rd_data   (rd_data),
    .sda_oe    (sda_oe),
    .busy      (bus_busy),
    .sel       (sel),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .cap_en    (cap_en)
  );

  i2cx_regs #(.DW(DATA_W), .RST_VALS(RST_VALS)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .sel     (sel),
    .wr_data (wr_data),
    .cap_en  (cap_en),
    .port_in (port_in),
    .rd_data (rd_data),
    .out_q   (out_q),
    .pol_q   (pol_q),
    .cfg_q   (cfg_q)
  );

endmodule

// File: rtl/i2cx_target_chk.sv
module i2cx_target_chk #(
  parameter int unsigned DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          scl_i,
  input logic          sda_oe,
  input logic          bus_busy,
  input logic          start_ev,
  input logic          stop_ev,
  input logic [DW-1:0] out_q,
  input logic [DW-1:0] pol_q,
  input logic [DW-1:0] cfg_q
);

  // R9
  sda_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !scl_i);

  // R8
  stop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_ev |=> (!bus_busy && !sda_oe));

  // R11
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_ev |=> bus_busy);

  // R1
  drive_in_txn_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> bus_busy);

  // R3
  regs_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_busy |=> ($stable(out_q) && $stable(pol_q) && $stable(cfg_q)));

endmodule

bind i2cx_target i2cx_target_chk #(.DW(DATA_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .scl_i    (scl_i),
  .sda_oe   (sda_oe),
  .bus_busy (bus_busy),
  .start_ev (start_ev),
  .stop_ev  (stop_ev),
  .out_q    (out_q),
  .pol_q    (pol_q),
  .cfg_q    (cfg_q)
);

// File: tb/i2cx_target_bench.sv
module i2cx_target_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       m_scl = 1'b1;
  logic       m_low = 1'b0;
  logic [2:0] addr_pins = 3'b000;
  logic [7:0] port_in = 8'h00;
  logic       sda_oe;
  logic [7:0] out_q, pol_q, cfg_q;
  logic       bus_busy;
  logic       sda_line;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct { logic [7:0] val; string req; } exp_t;
  exp_t exp_q[$];
  logic [7:0] rx_byte;
  event rx_ev;

  always #2 clk = ~clk;

  assign sda_line = ~(m_low | sda_oe);

  i2cx_target u_i2cx_target (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (m_scl),
    .sda_i     (sda_line),
    .sda_oe    (sda_oe),
    .addr_pins (addr_pins),
    .port_in   (port_in),
    .out_q     (out_q),
    .pol_q     (pol_q),
    .cfg_q     (cfg_q),
    .bus_busy  (bus_busy)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic expect_rd(input logic [7:0] v, input string req);
    exp_t e;
    e.val = v;
    e.req = req;
    exp_q.push_back(e);
  endtask

  // Scoreboard monitor: compares each received byte against the queue head
  initial begin
    forever begin
      @(rx_ev);
      if (exp_q.size() == 0) begin
        chk("scoreboard-unexpected", rx_byte, 8'hxx);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        chk(e.req, rx_byte, e.val);
      end
    end
  end

  task automatic qtr();
    repeat (8) @(posedge clk);
    #1;
  endtask

  task automatic bus_start();
    m_low = 1'b0; qtr();
    m_scl = 1'b1; qtr();
    m_low = 1'b1; qtr();
    m_scl = 1'b0; qtr();
  endtask

  task automatic bus_stop();
    m_scl = 1'b0;
    m_low = 1'b1; qtr();
    m_scl = 1'b1; qtr();
    m_low = 1'b0; qtr();
  endtask

  task automatic send_bit(input bit b);
    m_low = ~b; qtr();
    m_scl = 1'b1; qtr(); qtr();
    m_scl = 1'b0; qtr();
  endtask

  task automatic recv_bit(output bit b);
    m_low = 1'b0; qtr();
    m_scl = 1'b1; qtr();
    b = sda_line; qtr();
    m_scl = 1'b0; qtr();
  endtask

  task automatic wr_byte(input logic [7:0] v, output bit ack);
    bit b;
    for (int i = 7; i >= 0; i--) send_bit(v[i]);
    recv_bit(b);
    ack = ~b;
  endtask

  // Reads one byte; optionally changes the pins after the ack clock rises
  task automatic rd_byte(input bit mack, input bit chg, input logic [7:0] np);
    logic [7:0] v;
    bit b;
    for (int i = 7; i >= 0; i--) begin
      recv_bit(b);
      v[i] = b;
    end
    m_low = mack; qtr();
    m_scl = 1'b1; qtr();
    if (chg) port_in = np;
    qtr();
    m_scl = 1'b0; qtr();
    rx_byte = v;
    ->rx_ev;
  endtask

  function automatic logic [7:0] dev(input bit rd);
    return {4'b0100, addr_pins, rd};
  endfunction

  task automatic wr_txn(input logic [7:0] cmd, input logic [7:0] d, input string req);
    bit ack;
    bus_start();
    wr_byte(dev(0), ack); chk({req, " addr ack"}, 8'(ack), 8'd1);
    wr_byte(cmd, ack);    chk({req, " cmd ack"}, 8'(ack), 8'd1);
    wr_byte(d, ack);      chk({req, " data ack"}, 8'(ack), 8'd1);
    bus_stop();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    bit ack;
    repeat (10) @(posedge clk);
    #1 rst_n = 1'b1;
    qtr();
    // R10 reset state
    chk("R10 sda_oe", 8'(sda_oe), 8'd0);
    chk("R10 busy", 8'(bus_busy), 8'd0);
    chk("R10 out", out_q, 8'hFF);
    chk("R10 pol", pol_q, 8'h00);
    chk("R10 cfg", cfg_q, 8'hFF);

    // R10 R5: bare read after reset uses pointer 0 (input register)
    port_in = 8'hA5;
    bus_start();
    chk("R11 busy after start", 8'(bus_busy), 8'd1);
    wr_byte(dev(1), ack); chk("R1 read addr ack", 8'(ack), 8'd1);
    expect_rd(8'hA5, "R10 bare read input");
    rd_byte(0, 0, 8'h00);
    chk("R6 released after nack", 8'(sda_oe), 8'd0);
    bus_stop();
    chk("R11 busy after stop", 8'(bus_busy), 8'd0);

    // R3 write output register
    wr_txn(8'h01, 8'h3C, "R3");
    chk("R3 out written", out_q, 8'h3C);

    // R3 burst write to config: last byte remains
    bus_start();
    wr_byte(dev(0), ack); chk("R1 addr ack", 8'(ack), 8'd1);
    wr_byte(8'h03, ack);  chk("R2 cmd3 ack", 8'(ack), 8'd1);
    wr_byte(8'h01, ack);  chk("R3 burst b0 ack", 8'(ack), 8'd1);
    wr_byte(8'h02, ack);  chk("R3 burst b1 ack", 8'(ack), 8'd1);
    wr_byte(8'hF0, ack);  chk("R3 burst b2 ack", 8'(ack), 8'd1);
    bus_stop();
    chk("R3 cfg last byte", cfg_q, 8'hF0);

    // R4 write to input register is acked and ignored
    wr_txn(8'h00, 8'h55, "R4");
    chk("R4 out untouched", out_q, 8'h3C);
    chk("R4 pol untouched", pol_q, 8'h00);
    chk("R4 cfg untouched", cfg_q, 8'hF0);

    // R5 R6: polarity write, then command-only write + repeated start read burst
    wr_txn(8'h02, 8'h0F, "R3 pol");
    chk("R3 pol written", pol_q, 8'h0F);
    bus_start();
    wr_byte(dev(0), ack);
    wr_byte(8'h02, ack);
    bus_start();
    wr_byte(dev(1), ack); chk("R5 read after Sr ack", 8'(ack), 8'd1);
    expect_rd(8'h0F, "R5 Sr read b0");
    rd_byte(1, 0, 8'h00);
    expect_rd(8'h0F, "R6 burst b1 same reg");
    rd_byte(1, 0, 8'h00);
    expect_rd(8'h0F, "R6 burst b2 same reg");
    rd_byte(0, 0, 8'h00);
    chk("R6 released after nack", 8'(sda_oe), 8'd0);
    bus_stop();

    // R7 R4: input capture at ack clock, XOR with polarity
    port_in = 8'h5A;
    bus_start();
    wr_byte(dev(0), ack);
    wr_byte(8'h00, ack);
    bus_start();
    wr_byte(dev(1), ack);
    expect_rd(8'h55, "R4 input xor pol");
    rd_byte(1, 1, 8'hC3);
    expect_rd(8'h55, "R7 captured before pin change");
    rd_byte(1, 0, 8'h00);
    expect_rd(8'hCC, "R7 new capture");
    rd_byte(0, 0, 8'h00);
    bus_stop();

    // R5 pointer persists across transactions
    bus_start();
    wr_byte(dev(0), ack);
    wr_byte(8'h01, ack);
    bus_stop();
    bus_start();
    wr_byte(dev(1), ack);
    expect_rd(8'h3C, "R5 bare read keeps pointer");
    rd_byte(0, 0, 8'h00);
    bus_stop();

    // R1 address mismatch
    addr_pins = 3'b101;
    bus_start();
    wr_byte({4'b0100, 3'b000, 1'b0}, ack); chk("R1 wrong addr nack", 8'(ack), 8'd0);
    wr_byte(8'h01, ack); chk("R1 ignored until start", 8'(ack), 8'd0);
    bus_stop();
    chk("R1 out unchanged", out_q, 8'h3C);
    wr_txn(8'h01, 8'h99, "R1 pins");
    chk("R1 out written via pins", out_q, 8'h99);

    // R2 invalid command
    bus_start();
    wr_byte(dev(0), ack);
    wr_byte(8'h07, ack); chk("R2 bad cmd nack", 8'(ack), 8'd0);
    wr_byte(8'h12, ack); chk("R2 data after bad cmd nack", 8'(ack), 8'd0);
    bus_stop();
    chk("R2 out unchanged", out_q, 8'h99);
    chk("R2 cfg unchanged", cfg_q, 8'hF0);
    bus_start();
    wr_byte(dev(1), ack);
    expect_rd(8'h99, "R2 pointer unchanged");
    rd_byte(0, 0, 8'h00);
    bus_stop();

    // R8 stop in the middle of a data byte
    bus_start();
    wr_byte(dev(0), ack);
    wr_byte(8'h01, ack);
    send_bit(0); send_bit(1); send_bit(0); send_bit(0);
    bus_stop();
    chk("R8 busy cleared", 8'(bus_busy), 8'd0);
    chk("R8 sda released", 8'(sda_oe), 8'd0);
    chk("R8 out unchanged", out_q, 8'h99);
    wr_txn(8'h01, 8'h77, "R8 recover");
    chk("R8 normal after abort", out_q, 8'h77);

    chk("scoreboard drained", 8'(exp_q.size()), 8'd0);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule